// File: doc/BRIEF.md
# Dual-Rail Serial Word Receiver

This block sits at the far end of a bit-serial link that uses level-encoded dual-rail signalling. The link has two wires, a state wire and a phase wire, and exactly one of them changes for each bit. The state wire carries the bit value. The phase wire changes when a bit repeats the previous value. The receiver compares the XOR of the two wires with a stored parity. When they differ, a new bit has arrived and the stored parity takes the new value.

A pointer advances on each bit and steers the bits into `LANES` interleaved sub-registers. Each sub-register therefore fills at only a fraction of the bit rate. When the last bit of a word arrives, the block gathers the lanes into one parallel word and presents it on a valid/ready output. In the same cycle it sends a single acknowledge pulse back to the transmitter, once per word rather than once per bit. The model runs on a clock that is faster than the rate of wire changes. `WORD_W` must be a multiple of `LANES`.

Top module: `ledr_word_rx`

## Requirements
- R1: After reset, `o_valid`, `o_ack` and `o_overrun` are 0, and the block expects both wires at 0 with stored parity 0 and no bits collected.
- R2: A bit is counted only when the XOR of the two wires changes. While both wires stay still, no word completes.
- R3: The value of each received bit is the level of the state wire after its change.
- R4: The first bit received after a word boundary lands in `o_word[0]`, and the i-th bit lands in `o_word[i]`.
- R5: Bit i of a word is collected in sub-register i mod `LANES`, at slot i / `LANES`. The assembled word equals the serial sequence for every bit pattern.
- R6: A wire change that carries the last bit of a word is followed two clock edges later by `o_valid` = 1 and a one-cycle `o_ack` pulse.
- R7: `o_word` and `o_valid` hold until a clock edge sees `i_ready` = 1 with `o_valid` = 1. That edge clears `o_valid`.
- R8: A bit that arrives while `o_valid` = 1 and `i_ready` = 0 raises `o_overrun` for one cycle, two edges after the change. The bit is still collected. A word that completes while the previous one is still pending replaces it.
- R9: After each word the bit count returns to zero, so consecutive words are framed independently.
- R10: A simultaneous change of both wires leaves the XOR unchanged and is not counted as a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, faster than the wire change rate |
| rst_n | input | 1 | Active-low synchronous reset |
| i_state | input | 1 | State wire of the dual-rail link (bit value) |
| i_phase | input | 1 | Phase wire of the dual-rail link |
| i_ready | input | 1 | Consumer accepts the presented word |
| o_word | output | WORD_W | Reassembled word, bit 0 received first |
| o_valid | output | 1 | Word available |
| o_ack | output | 1 | One-cycle acknowledge to the transmitter per word |
| o_overrun | output | 1 | One-cycle flag for a bit arriving during a pending word |

## Verification
Words are sent as all zeros, all ones and the two alternating patterns. All-zero and all-one words force every bit after the first onto the phase wire, while the alternating patterns keep every change on the state wire. Walking-one words and a multiplicative sequence of words show whether each bit reaches its own lane and slot, and whether any bit is shifted or swapped. Extra scenarios cover a simultaneous change of both wires, a bit sent while a word is still pending, and back-to-back framing.

// File: rtl/ledr_word_rx.sv
module ledr_word_rx #(
  parameter int WORD_W = 16,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_state,
  input  logic              i_phase,
  input  logic              i_ready,
  output logic [WORD_W-1:0] o_word,
  output logic              o_valid,
  output logic              o_ack,
  output logic              o_overrun
);
  localparam int DEPTH = WORD_W / LANES;
  localparam int PW    = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int SW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic          s_q, p_q, par_q;
  logic [PW-1:0] ptr_q;
  logic [SW-1:0] slot_q;
  logic [WORD_W-1:0] asm_w;

  wire hit  = (s_q ^ p_q) != par_q;
  wire lane_end = ptr_q == PW'(LANES - 1);
  wire last = hit && lane_end && slot_q == SW'(DEPTH - 1);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [DEPTH-1:0] bits_q;
    wire take = hit && ptr_q == PW'(l);

    always_ff @(posedge clk) begin
      if (!rst_n) bits_q <= '0;
      else if (take) bits_q[slot_q] <= s_q;
    end

    for (genvar k = 0; k < DEPTH; k++) begin : g_slot
      assign asm_w[k*LANES + l] = (take && slot_q == SW'(k)) ? s_q : bits_q[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_q       <= 1'b0;
      p_q       <= 1'b0;
      par_q     <= 1'b0;
      ptr_q     <= '0;
      slot_q    <= '0;
      o_word    <= '0;
      o_valid   <= 1'b0;
      o_ack     <= 1'b0;
      o_overrun <= 1'b0;
    end else begin
      s_q       <= i_state;
      p_q       <= i_phase;
      o_ack     <= last;
      o_overrun <= hit && o_valid && !i_ready;
      if (hit) begin
        par_q <= s_q ^ p_q;
        if (last) begin
          ptr_q  <= '0;
          slot_q <= '0;
        end else if (lane_end) begin
          ptr_q  <= '0;
          slot_q <= slot_q + SW'(1);
        end else begin
          ptr_q  <= ptr_q + PW'(1);
        end
      end
      if (last) begin
        o_word  <= asm_w;
        o_valid <= 1'b1;
      end else if (i_ready) begin
        o_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ledr_word_rx_chk.sv
module ledr_word_rx_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              i_ready,
  input logic              hit,
  input logic [WORD_W-1:0] o_word,
  input logic              o_valid,
  input logic              o_ack,
  input logic              o_overrun
);
  AST_ACK_MEANS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    o_ack |-> o_valid); // R6
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    o_ack |=> !o_ack); // R6
  AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !i_ready) |=> (o_valid && (o_ack || $stable(o_word)))); // R7
  AST_OVR_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    o_overrun |-> $past(o_valid && !i_ready)); // R8
  AST_IDLE_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> !o_ack); // R2
endmodule

bind ledr_word_rx ledr_word_rx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .i_ready(i_ready), .hit(hit),
  .o_word(o_word), .o_valid(o_valid), .o_ack(o_ack), .o_overrun(o_overrun)
);

// File: tb/ledr_word_rx_bench.sv
module ledr_word_rx_bench;
  localparam int W = 16;
  logic clk = 0, rst_n = 0, st = 0, ph = 0, rdy = 0;
  logic [W-1:0] word;
  logic valid, ack, ovr;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ledr_word_rx #(.WORD_W(W), .LANES(4)) u_ledr_word_rx (
    .clk(clk), .rst_n(rst_n), .i_state(st), .i_phase(ph), .i_ready(rdy),
    .o_word(word), .o_valid(valid), .o_ack(ack), .o_overrun(ovr));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(logic b);
    @(negedge clk);
    if (b != st) st = b; else ph = ~ph;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_word(logic [W-1:0] w, string req);
    for (int i = 0; i < W; i++) begin
      send_bit(w[i]);
      if (i == W - 2) check({req, " R2 no early valid"}, 32'(valid), 0);
    end
    check("R6 valid", 32'(valid), 1);
    check("R6 ack", 32'(ack), 1);
    check({req, " word"}, 32'(word), 32'(w));
  endtask

  task automatic accept(logic [W-1:0] w);
    @(negedge clk);
    check("R6 ack one cycle", 32'(ack), 0);
    check("R7 held", 32'(valid), 1);
    check("R7 word held", 32'(word), 32'(w));
    rdy = 1;
    @(negedge clk);
    rdy = 0;
    check("R7 taken", 32'(valid), 0);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 valid", 32'(valid), 0);
    check("R1 ack", 32'(ack), 0);
    check("R1 ovr", 32'(ovr), 0);
    repeat (5) @(negedge clk);
    check("R2 idle", 32'(valid), 0);

    send_word(16'h0000, "R3"); accept(16'h0000);
    send_word(16'hFFFF, "R3"); accept(16'hFFFF);
    send_word(16'hAAAA, "R5"); accept(16'hAAAA);
    send_word(16'h5555, "R5"); accept(16'h5555);
    for (int i = 0; i < W; i++) begin
      w = W'(1) << i;
      send_word(w, "R4");
      accept(w);
    end
    for (int i = 1; i <= 8; i++) begin
      w = W'(i * 40503 + 12345);
      send_word(w, "R9");
      accept(w);
    end

    @(negedge clk);
    st = ~st; ph = ~ph;
    repeat (4) @(negedge clk);
    check("R10 no bit", 32'(valid), 0);
    send_word(16'h3C96, "R10"); accept(16'h3C96);

    send_word(16'h1234, "R8");
    w = 16'hBEEF;
    send_bit(w[0]);
    check("R8 overrun", 32'(ovr), 1);
    check("R8 old word kept", 32'(word), 32'h1234);
    @(negedge clk);
    check("R8 pulse", 32'(ovr), 0);
    for (int i = 1; i < W; i++) send_bit(w[i]);
    check("R8 replaced", 32'(word), 32'(w));
    check("R8 valid", 32'(valid), 1);
    accept(w);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule